// File: doc/BRIEF.md
# Chained Output DMA Engine

This block is the transmit half of a single DMA channel. Software builds a chain of data descriptors in memory and gives the engine a start pulse together with the address of the first descriptor. The engine reads each descriptor through a word-wide request/acknowledge memory port. It then reads the bytes of the buffer the descriptor points at and sends them to a client, one byte per beat, over a valid/ready stream.

A buffer ends when the engine's running byte pointer reaches the descriptor's end pointer. No length counter is used. At that point the engine raises a one-cycle data interrupt if the descriptor asks for one. It writes the four descriptor words back to their original location. It then either follows the next pointer or, if the descriptor is marked as the end of the list, latches an end-of-list flag and goes quiet until the next start pulse.

Data moves in steps of at most `MAX_STEP` bytes. Between two steps inside one buffer, the engine leaves the stream idle for one cycle.

Top module: `dmaout_engine`

## Requirements
- R1: After reset the engine makes no memory request, shows no stream beat, gives no interrupt pulse, and `eol_flag` is low.
- R2: A start pulse while idle causes reads of the four descriptor words at `first_desc`, +4, +8 and +12, in that order. Word 0 is the next-descriptor pointer, word 1 the buffer start, word 2 the flags, and word 3 the end pointer. The end pointer is the first byte address past the buffer.
- R3: The stream carries every byte from the buffer start address up to the end pointer minus one, in ascending address order. Buffer words are read at word-aligned addresses. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the word at a with its two low bits cleared (little-endian).
- R4: Once `st_valid` is high, it stays high with `st_data` and `st_last` unchanged until a cycle in which `st_ready` is high.
- R5: At most `MAX_STEP` bytes of one buffer move in one step. When a beat completes a step and bytes of the buffer remain, `st_valid` is low in the next cycle.
- R6: `st_last` is high on the final byte of a buffer exactly when bit 3 of that descriptor's flags word is set.
- R7: When a buffer is finished and bit 4 of its flags word is set, `data_irq` is high for exactly one cycle. If bit 4 is clear, no pulse occurs.
- R8: After a buffer is finished, the four descriptor words are written back unchanged to the addresses they were read from, in order 0 to 3. This happens before any further memory access.
- R9: If bit 0 of the flags word is clear, the next descriptor is fetched from the address held in word 0. If bit 0 is set, `eol_flag` goes high and the engine makes no request and shows no beat until a new start pulse.
- R10: A start pulse that arrives while a chain is being walked has no effect.
- R11: A descriptor whose end pointer equals its start pointer produces no stream beat, is still written back, and is still followed to the next descriptor.
- R12: A start pulse after the end of a list clears `eol_flag` in the following cycle and begins a new fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that begins a chain walk when idle |
| first_desc | input | 32 | Byte address of the first descriptor |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | High for a write (descriptor write-back), low for a read |
| mem_addr | output | 32 | Word-aligned byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes in a cycle where this and `mem_req` are high |
| mem_rdata | input | 32 | Read data, valid together with `mem_ack` |
| st_valid | output | 1 | Stream byte available |
| st_data | output | 8 | Stream byte |
| st_last | output | 1 | Final byte of a buffer whose descriptor requests an end-of-packet mark |
| st_ready | input | 1 | Client accepts the byte |
| data_irq | output | 1 | One-cycle data interrupt set pulse |
| eol_flag | output | 1 | End of list reached; engine halted |

## Verification
The hardest situation to reach from the ports is the step boundary that falls inside a word the engine already holds. At that point, only the enforced idle cycle separates the two steps, and the idle cycle must not appear when the step ends exactly at the end of the buffer. The bench lowers the step limit to six bytes. It places aligned and unaligned buffers of 5, 6, 11 and 12 bytes around that limit, and checks for the idle cycle only after beats that end a step with bytes left. Memory latency varies from zero to two wait cycles and the client's ready signal is pseudo-random. Together these cover held beats, refetches and zero-length descriptors. A stray start pulse is also injected in the middle of a walk.

// File: rtl/dmaout_pkg.sv
package dmaout_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned LANES      = WORD_W / BYTE_W;
  localparam int unsigned LANE_W     = $clog2(LANES);
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned DIDX_W     = $clog2(DESC_WORDS);

  // descriptor word order is fixed by the in-memory layout
  localparam logic [DIDX_W-1:0] DW_NEXT  = DIDX_W'(0);
  localparam logic [DIDX_W-1:0] DW_BUF   = DIDX_W'(1);
  localparam logic [DIDX_W-1:0] DW_FLAGS = DIDX_W'(2);
  localparam logic [DIDX_W-1:0] DW_AFTER = DIDX_W'(3);

  // flag bit positions inside the flags word
  localparam int unsigned FL_EOL     = 0;
  localparam int unsigned FL_OUT_EOP = 3;
  localparam int unsigned FL_INTR    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_XFER,
    ST_GAP,
    ST_WBACK
  } eng_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] nxt;
    logic [WORD_W-1:0] bufp;
    logic [WORD_W-1:0] flags;
    logic [WORD_W-1:0] after;
  } desc_t;

endpackage

// File: rtl/dmaout_desc_regs.sv
module dmaout_desc_regs
  import dmaout_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DIDX_W-1:0] wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [DIDX_W-1:0] rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output desc_t             desc
);

  logic [DESC_WORDS-1:0][WORD_W-1:0] words;

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    logic              sel;
    logic [WORD_W-1:0] q;
    logic [WORD_W-1:0] d;

    assign sel = wr_en && (wr_idx == DIDX_W'(g));

    always_comb begin
      d = q;
      if (sel) d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign words[g] = q;
  end

  assign rd_word    = words[rd_idx];
  assign desc.nxt   = words[DW_NEXT];
  assign desc.bufp  = words[DW_BUF];
  assign desc.flags = words[DW_FLAGS];
  assign desc.after = words[DW_AFTER];

endmodule

// File: rtl/dmaout_word_hold.sv
module dmaout_word_hold
  import dmaout_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [WORD_W-1:0] ptr,
  output logic              hit,
  output logic [BYTE_W-1:0] lane_byte
);

  localparam int unsigned TAG_W = WORD_W - LANE_W;

  logic              vld_q, vld_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    vld_d  = vld_q;
    tag_d  = tag_q;
    word_d = word_q;
    if (clr) begin
      vld_d = 1'b0;
    end else if (load) begin
      vld_d  = 1'b1;
      tag_d  = ptr[WORD_W-1:LANE_W];
      word_d = load_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      word_q <= '0;
    end else begin
      vld_q  <= vld_d;
      tag_q  <= tag_d;
      word_q <= word_d;
    end
  end

  assign hit       = vld_q && (tag_q == ptr[WORD_W-1:LANE_W]);
  assign lane_byte = word_q[BYTE_W*ptr[LANE_W-1:0] +: BYTE_W];

  // R3: a held word is only replaced on a miss
  a_r3_load_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !hit);

endmodule

// File: rtl/dmaout_step.sv
module dmaout_step #(
  parameter int unsigned MAX_STEP = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic step_last
);

  localparam int unsigned CNT_W = $clog2(MAX_STEP + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign step_last = (cnt_q == CNT_W'(MAX_STEP - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = step_last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: the count of bytes in one step never reaches the limit
  a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_STEP));

endmodule

// File: rtl/dmaout_engine.sv
module dmaout_engine
  import dmaout_pkg::*;
#(
  parameter int unsigned MAX_STEP = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] first_desc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              st_valid,
  output logic [BYTE_W-1:0] st_data,
  output logic              st_last,
  input  logic              st_ready,
  output logic              data_irq,
  output logic              eol_flag
);

  localparam logic [DIDX_W-1:0] WIDX_LAST = DIDX_W'(DESC_WORDS - 1);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n = rst_sync_q[1];

  eng_state_e        state_q, state_d;
  logic [DIDX_W-1:0] widx_q, widx_d;
  logic [WORD_W-1:0] daddr_q, daddr_d;
  logic [WORD_W-1:0] cur_q, cur_d;
  logic              eol_q, eol_d;
  logic              irq_q, irq_d;

  desc_t             desc;
  logic [WORD_W-1:0] wb_word;
  logic              desc_wr;
  logic              hold_clr, hold_load, hit;
  logic [BYTE_W-1:0] lane_byte;
  logic              step_last;
  logic              at_end, widx_last, beat;
  logic [WORD_W-1:0] cur_inc, desc_word_addr;
  logic              unused_flags;

  assign unused_flags = ^{desc.flags[WORD_W-1:FL_INTR+1],
                          desc.flags[FL_OUT_EOP-1:FL_EOL+1]};

  assign at_end         = (cur_q == desc.after);
  assign cur_inc        = cur_q + WORD_W'(1);
  assign widx_last      = (widx_q == WIDX_LAST);
  assign desc_word_addr = daddr_q + (WORD_W'(widx_q) << LANE_W);

  // stream side
  assign st_valid = (state_q == ST_XFER) && !at_end && hit;
  assign st_data  = lane_byte;
  assign st_last  = st_valid && (cur_inc == desc.after) && desc.flags[FL_OUT_EOP];
  assign beat     = st_valid && st_ready;

  // memory side
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_word_addr;
    mem_wdata = wb_word;
    unique case (state_q)
      ST_FETCH: mem_req = 1'b1;
      ST_WBACK: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      ST_XFER: begin
        mem_req  = !at_end && !hit;
        mem_addr = {cur_q[WORD_W-1:LANE_W], {LANE_W{1'b0}}};
      end
      default: ;
    endcase
  end

  assign desc_wr   = (state_q == ST_FETCH) && mem_ack;
  assign hold_clr  = desc_wr && widx_last;
  assign hold_load = (state_q == ST_XFER) && mem_req && mem_ack;

  dmaout_desc_regs u_desc (
    .clk     (clk),
    .rst_n   (arst_n),
    .wr_en   (desc_wr),
    .wr_idx  (widx_q),
    .wr_data (mem_rdata),
    .rd_idx  (widx_q),
    .rd_word (wb_word),
    .desc    (desc)
  );

  dmaout_word_hold u_hold (
    .clk       (clk),
    .rst_n     (arst_n),
    .clr       (hold_clr),
    .load      (hold_load),
    .load_word (mem_rdata),
    .ptr       (cur_q),
    .hit       (hit),
    .lane_byte (lane_byte)
  );

  dmaout_step #(.MAX_STEP(MAX_STEP)) u_step (
    .clk       (clk),
    .rst_n     (arst_n),
    .clr       (hold_clr),
    .inc       (beat),
    .step_last (step_last)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    widx_d  = widx_q;
    daddr_d = daddr_q;
    cur_d   = cur_q;
    eol_d   = eol_q;
    irq_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          daddr_d = first_desc;
          widx_d  = '0;
          eol_d   = 1'b0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          if (widx_last) begin
            cur_d   = desc.bufp;
            state_d = ST_XFER;
          end else begin
            widx_d = widx_q + DIDX_W'(1);
          end
        end
      end
      ST_XFER: begin
        if (at_end) begin
          irq_d   = desc.flags[FL_INTR];
          widx_d  = '0;
          state_d = ST_WBACK;
        end else if (beat) begin
          cur_d = cur_inc;
          if (step_last && (cur_inc != desc.after)) state_d = ST_GAP;
        end
      end
      ST_GAP: state_d = ST_XFER;
      ST_WBACK: begin
        if (mem_ack) begin
          if (widx_last) begin
            if (desc.flags[FL_EOL]) begin
              eol_d   = 1'b1;
              state_d = ST_IDLE;
            end else begin
              daddr_d = desc.nxt;
              widx_d  = '0;
              state_d = ST_FETCH;
            end
          end else begin
            widx_d = widx_q + DIDX_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
      daddr_q <= '0;
      cur_q   <= '0;
      eol_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      widx_q  <= widx_d;
      daddr_q <= daddr_d;
      cur_q   <= cur_d;
      eol_q   <= eol_d;
      irq_q   <= irq_d;
    end
  end

  assign data_irq = irq_q;
  assign eol_flag = eol_q;

  // R4: a beat on offer is held until taken
  a_r4_beat_hold: assert property (@(posedge clk) disable iff (!arst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_last));

  // R8: a memory request is held unchanged until acknowledged
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!arst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata));

  // R7: the data interrupt is a single-cycle pulse
  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!arst_n)
    data_irq |=> !data_irq);

  // R9: a halted channel is silent
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!arst_n)
    eol_flag |-> !st_valid && !mem_req);

  // R5: a full step with bytes left is followed by an idle stream cycle
  a_r5_step_gap: assert property (@(posedge clk) disable iff (!arst_n)
    beat && step_last && (cur_inc != desc.after) |=> !st_valid);

  // R6: the last marker only rides on a real beat
  a_r6_last_valid: assert property (@(posedge clk) disable iff (!arst_n)
    st_last |-> st_valid);

endmodule

// File: tb/dmaout_engine_test.sv
module dmaout_engine_test;

  localparam int STEP = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] first_desc = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        st_valid, st_last;
  logic [7:0]  st_data;
  logic        st_ready = 1'b0;
  logic        data_irq, eol_flag;

  always #4 clk = ~clk;

  dmaout_engine #(.MAX_STEP(STEP)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .first_desc (first_desc),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .st_valid   (st_valid),
    .st_data    (st_data),
    .st_last    (st_last),
    .st_ready   (st_ready),
    .data_irq   (data_irq),
    .eol_flag   (eol_flag)
  );

  typedef struct {
    logic [7:0] b;
    logic       last;
    logic       gap;
  } beat_t;

  logic [31:0] mem [0:511];
  beat_t       exp_beats[$];
  logic [31:0] exp_dread[$];
  logic [63:0] exp_wb[$];
  int checks = 0, errors = 0, irq_seen = 0, irq_exp = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: 0..2 wait cycles, rotating
  int lat = 0, waitc = 0;
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (waitc >= lat) begin
        waitc = 0;
        lat = (lat + 1) % 3;
        mem_ack = 1'b1;
        if (mem_we) begin
          if (exp_wb.size() == 0) check(0, "R8", "unexpected write", mem_addr, 0);
          else begin
            logic [63:0] e;
            e = exp_wb.pop_front();
            check({mem_addr, mem_wdata} == e, "R8", "write-back addr/data",
                  {mem_addr, mem_wdata}, e);
          end
          mem[mem_addr[10:2]] = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[10:2]];
          check(mem_addr[1:0] == 2'b00, "R3", "aligned read", mem_addr, {mem_addr[31:2], 2'b00});
          if (mem_addr < 32'h100) begin
            if (exp_dread.size() == 0) check(0, "R2", "unexpected descriptor read", mem_addr, 0);
            else begin
              logic [31:0] a;
              a = exp_dread.pop_front();
              check(mem_addr == a, "R2", "descriptor read address", mem_addr, a);
            end
          end
        end
      end else begin
        waitc++;
      end
    end
  end

  // client and monitor
  logic [15:0] lfsr = 16'hACE1;
  bit          gap_pend = 0, hold_pend = 0;
  logic [7:0]  hold_data;
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (gap_pend) begin
      check(!st_valid, "R5", "idle cycle after full step", st_valid, 0);
      gap_pend = 0;
    end
    if (hold_pend) begin
      check(st_valid && st_data == hold_data, "R4", "beat held until ready",
            {st_valid, st_data}, {1'b1, hold_data});
      hold_pend = 0;
    end
    st_ready = rst_n && (lfsr[0] | lfsr[1]);
    if (st_valid && !st_ready) begin
      hold_pend = 1;
      hold_data = st_data;
    end
    if (st_valid && st_ready) begin
      if (exp_beats.size() == 0) check(0, "R3", "unexpected beat", st_data, 0);
      else begin
        beat_t e;
        e = exp_beats.pop_front();
        check(st_data == e.b, "R3", "stream byte", st_data, e.b);
        check(st_last == e.last, "R6", "last marker", st_last, e.last);
        gap_pend = e.gap;
      end
    end
    if (data_irq) irq_seen++;
  end

  // driver: place a descriptor and queue what the walk must produce
  task automatic add_desc(input logic [31:0] a, input logic [31:0] nxt,
                          input logic [31:0] bp, input logic [31:0] aft,
                          input logic [31:0] flags);
    logic [31:0] w [4];
    w[0] = nxt; w[1] = bp; w[2] = flags; w[3] = aft;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] wa;
      wa = a + 32'(4 * i);
      mem[wa[10:2]] = w[i];
      exp_dread.push_back(wa);
    end
    for (logic [31:0] x = bp; x < aft; x++) begin
      beat_t it;
      it.b    = mem[x[10:2]][8*x[1:0] +: 8];
      it.last = (x == aft - 1) && flags[3];
      it.gap  = (((x - bp + 1) % STEP) == 0) && (x + 1 < aft);
      exp_beats.push_back(it);
    end
    for (int i = 0; i < 4; i++) exp_wb.push_back({a + 32'(4 * i), w[i]});
    if (flags[4]) irq_exp++;
  endtask

  task automatic run_chain(input logic [31:0] fa, input bit poke);
    int n;
    @(negedge clk);
    first_desc = fa;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!eol_flag, "R12", "eol cleared after start", eol_flag, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      // R10: stray start while walking must change nothing
      first_desc = 32'h0000_00C0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!eol_flag && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(eol_flag, "R9", "end of list reached", eol_flag, 1);
    repeat (3) @(negedge clk);
    check(exp_beats.size() == 0, "R3", "all bytes streamed", exp_beats.size(), 0);
    check(exp_dread.size() == 0, "R2", "all descriptors fetched", exp_dread.size(), 0);
    check(exp_wb.size() == 0, "R8", "all write-backs done", exp_wb.size(), 0);
    check(irq_seen == irq_exp, "R7", "data interrupt count", irq_seen, irq_exp);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(!mem_req && !st_valid, "R9", "halted channel quiet", {mem_req, st_valid}, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      logic [7:0] k;
      k = 8'(i);
      mem[i] = {k ^ 8'h3C, k + 8'h11, ~k, k * 8'd3};
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!mem_req && !st_valid && !data_irq && !eol_flag, "R1", "reset state",
          {mem_req, st_valid, data_irq, eol_flag}, 0);

    // two descriptors: aligned 12 bytes with irq+eop, unaligned 11 bytes ending the list
    add_desc(32'h00, 32'h10, 32'h100, 32'h10C, 32'h0001_0018);
    add_desc(32'h10, 32'h00, 32'h203, 32'h20E, 32'h0000_0001);
    run_chain(32'h00, 1'b1);

    // zero-length descriptor (R11), then a short tail with eop and irq; restart after eol (R12)
    add_desc(32'h20, 32'h30, 32'h300, 32'h300, 32'h0000_0010);
    add_desc(32'h30, 32'h00, 32'h301, 32'h306, 32'h0000_0019);
    run_chain(32'h20, 1'b0);

    // buffer exactly one step long: no idle cycle at its end, no irq
    add_desc(32'h40, 32'h00, 32'h400, 32'h406, 32'h0000_0001);
    run_chain(32'h40, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=running expected=halted");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule